// File: doc/BRIEF.md
# Edge-Triggered External Interrupt and Event Line Controller

This block collects external signals and turns them into interrupt requests and event pulses. Its lines come in two kinds. A configurable line passes its source through a two-flop synchronizer. It then looks for a rising transition, a falling transition or both, as software chooses, and latches a pending flag when one is seen. An interrupt mask gates the pending flag onto the line's interrupt output. A separate event mask turns the same trigger into a pulse one clock wide. Software can also raise a pending flag by writing a trigger register. It clears flags by writing ones to the pending register. A direct line has no edge logic: its level goes straight to the outputs, gated only by the two masks.

The low sixteen configurable lines each take their source from a per-line multiplexer. The multiplexer picks pin i of one of several GPIO ports, and a 4-bit select field per line chooses the port. The remaining configurable lines have dedicated source inputs. Two grouped outputs OR the interrupt outputs of lines 5 to 9 and of lines 10 to 15, so several lines can share one interrupt vector. All settings are reached through a simple word-addressed bus, one word per register.

Top module: `extint_ctrl`

## Requirements
- R1: After reset every register reads 0. `irq_line`, `evt_pulse`, `irq_grp_lo` and `irq_grp_hi` are all 0 while the inputs are low.
- R2: With a line's rising enable set, a 0 to 1 change of its source sets the pending bit. The change is made just after a clock edge, and the bit is set after the third following rising clock edge. With only the rising enable set, a 1 to 0 change sets nothing.
- R3: With a line's falling enable set, a 1 to 0 change sets the pending bit with the same latency. With both enables set, either direction sets it. With neither set, no change sets it.
- R4: `irq_line[i]` of a configurable line equals its pending bit ANDed with interrupt mask bit i. A masked line still latches its pending bit, and the bit can be read back.
- R5: When event mask bit i is set, a trigger on configurable line i drives `evt_pulse[i]` high for exactly one cycle. That cycle is the one in which the pending bit first reads 1. The pulse does not depend on the interrupt mask.
- R6: Writing 1 to bit i of the software trigger register (address 4) sets pending bit i and trigger bit i at the next clock edge, with the same event pulse as an edge. Writing 0 to a bit changes nothing.
- R7: Writing 1 to bit i of the pending register (address 5) clears pending bit i and software trigger bit i. Writing 0 to a bit leaves it unchanged.
- R8: If a hardware trigger and a write-1 clear hit the same line in the same cycle, the pending bit stays set.
- R9: Direct lines N_CFG and up drive `irq_line` = source AND interrupt mask and `evt_pulse` = source AND event mask, with no clock delay. Their pending bits always read 0, and their rising and falling enable bits read 0 and do nothing.
- R10: Line i below 16 takes its source from `gpio_in[16*p+i]`, where p is the 4-bit select field at bits 4*(i%8)+3..4*(i%8). That field is in the word at address 6 for lines 0-7 and at address 7 for lines 8-15. Pins of ports that are not selected have no effect, and a select value of N_PORTS or more gives a constant 0.
- R11: `irq_grp_lo` is the OR of `irq_line[9:5]` and `irq_grp_hi` is the OR of `irq_line[15:10]`.
- R12: The register map is: address 0 interrupt mask, 1 event mask, 2 rising enable, 3 falling enable, 4 software trigger, 5 pending, 6 and 7 port select. Reads are combinational while `bus_en` is high and `bus_we` is low. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | 16*N_PORTS | GPIO pins, port p at bits 16p+15..16p |
| hi_src | input | N_CFG-16 | Sources of configurable lines 16 and up |
| dir_src | input | N_LINES-N_CFG | Level sources of the direct lines |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq_line | output | N_LINES | Per-line interrupt requests |
| evt_pulse | output | N_LINES | Per-line event outputs |
| irq_grp_lo | output | 1 | Shared interrupt of lines 5-9 |
| irq_grp_hi | output | 1 | Shared interrupt of lines 10-15 |

## Verification
A stale or lost pending bit shows up on `irq_line` and in the pending readback one cycle after the trigger should have registered. A wrong synchronizer depth shifts that by one or more cycles, which the fixed three-edge sampling point exposes. A swapped edge polarity or a wrong port-select index sets the pending bit for a transition that should have been ignored, or fails to set it, and this is visible within four cycles. A software trigger bit that survives a clear is seen at once in its readback.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int PIN_W   = 16;
  localparam int FIELD_W = 4;

  localparam logic [3:0] A_IMASK = 4'd0;
  localparam logic [3:0] A_EMASK = 4'd1;
  localparam logic [3:0] A_RISE  = 4'd2;
  localparam logic [3:0] A_FALL  = 4'd3;
  localparam logic [3:0] A_SWT   = 4'd4;
  localparam logic [3:0] A_PEND  = 4'd5;
  localparam logic [3:0] A_PSEL0 = 4'd6;
  localparam logic [3:0] A_PSEL1 = 4'd7;

  // Port-select field of one low line, taken from the two select words.
  function automatic logic [FIELD_W-1:0] psel_field(input logic [31:0] w_lo,
                                                     input logic [31:0] w_hi,
                                                     input int line);
    if (line < 8) return w_lo[line*FIELD_W +: FIELD_W];
    else          return w_hi[(line-8)*FIELD_W +: FIELD_W];
  endfunction

  // A trigger is a selected transition between two synchronized samples.
  function automatic logic edge_hit(input logic rise_en, input logic fall_en,
                                    input logic cur, input logic prev);
    return (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
  endfunction
endpackage

// File: rtl/extint_port_mux.sv
module extint_port_mux import extint_pkg::*; #(
  parameter int N_PORTS = 4,
  parameter int N_MUX   = 16
) (
  input  logic [N_PORTS*PIN_W-1:0] gpio_in,
  input  logic [31:0]              psel_lo,
  input  logic [31:0]              psel_hi,
  output logic [N_MUX-1:0]         mux_out
);
  for (genvar i = 0; i < N_MUX; i++) begin : g_line
    logic [FIELD_W-1:0] sel;
    always_comb begin
      sel = psel_field(psel_lo, psel_hi, i);
      mux_out[i] = 1'b0;
      for (int p = 0; p < N_PORTS; p++)
        if (sel == FIELD_W'(p)) mux_out[i] = gpio_in[p*PIN_W + i];
    end
  end
endmodule

// File: rtl/extint_edge_detect.sv
module extint_edge_detect import extint_pkg::*; #(
  parameter int N = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  output logic [N-1:0] trig_hw
);
  logic [N-1:0] sync1, sync2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign trig_hw[i] = edge_hit(rise_en[i], fall_en[i], sync2[i], prev[i]);
  end
endmodule

// File: rtl/extint_regs.sv
module extint_regs import extint_pkg::*; #(
  parameter int N_CFG   = 26,
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [N_CFG-1:0]   trig_hw,
  output logic [N_LINES-1:0] imask,
  output logic [N_LINES-1:0] emask,
  output logic [N_CFG-1:0]   rise_en,
  output logic [N_CFG-1:0]   fall_en,
  output logic [31:0]        psel_lo,
  output logic [31:0]        psel_hi,
  output logic [N_CFG-1:0]   pend,
  output logic [N_CFG-1:0]   evt_cfg
);
  logic             wr;
  logic [N_CFG-1:0] sw_set, clr, trig_all, swt;

  assign wr       = bus_en & bus_we;
  assign sw_set   = (wr && bus_addr == A_SWT)  ? bus_wdata[N_CFG-1:0] : '0;
  assign clr      = (wr && bus_addr == A_PEND) ? bus_wdata[N_CFG-1:0] : '0;
  assign trig_all = trig_hw | sw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask   <= '0;
      emask   <= '0;
      rise_en <= '0;
      fall_en <= '0;
      psel_lo <= '0;
      psel_hi <= '0;
      pend    <= '0;
      swt     <= '0;
      evt_cfg <= '0;
    end else begin
      if (wr && bus_addr == A_IMASK) imask   <= bus_wdata[N_LINES-1:0];
      if (wr && bus_addr == A_EMASK) emask   <= bus_wdata[N_LINES-1:0];
      if (wr && bus_addr == A_RISE)  rise_en <= bus_wdata[N_CFG-1:0];
      if (wr && bus_addr == A_FALL)  fall_en <= bus_wdata[N_CFG-1:0];
      if (wr && bus_addr == A_PSEL0) psel_lo <= bus_wdata;
      if (wr && bus_addr == A_PSEL1) psel_hi <= bus_wdata;
      pend    <= (pend & ~clr) | trig_all;
      swt     <= (swt & ~(clr & ~trig_all)) | sw_set;
      evt_cfg <= trig_all & emask[N_CFG-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr)
        A_IMASK: bus_rdata[N_LINES-1:0] = imask;
        A_EMASK: bus_rdata[N_LINES-1:0] = emask;
        A_RISE:  bus_rdata[N_CFG-1:0]   = rise_en;
        A_FALL:  bus_rdata[N_CFG-1:0]   = fall_en;
        A_SWT:   bus_rdata[N_CFG-1:0]   = swt;
        A_PEND:  bus_rdata[N_CFG-1:0]   = pend;
        A_PSEL0: bus_rdata              = psel_lo;
        A_PSEL1: bus_rdata              = psel_hi;
        default: bus_rdata              = '0;
      endcase
    end
  end

  AST_PEND_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_all) |=> ((pend & $past(trig_all)) == $past(trig_all))); // R8
  AST_NO_SPONT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(trig_all)) == '0)); // R2
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((pend & $past(clr & ~trig_all)) == '0)); // R7
  AST_SWT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((swt & $past(clr & ~trig_all)) == '0)); // R7
  AST_EVT_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_cfg & ~pend) == '0)); // R5
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl import extint_pkg::*; #(
  parameter int N_PORTS = 4,
  parameter int N_CFG   = 26,
  parameter int N_LINES = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORTS*PIN_W-1:0] gpio_in,
  input  logic [N_CFG-PIN_W-1:0]   hi_src,
  input  logic [N_LINES-N_CFG-1:0] dir_src,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [3:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [N_LINES-1:0]       irq_line,
  output logic [N_LINES-1:0]       evt_pulse,
  output logic                     irq_grp_lo,
  output logic                     irq_grp_hi
);
  localparam int GLO_L = 5, GLO_H = 9, GHI_L = 10, GHI_H = 15;

  logic [PIN_W-1:0]   mux_out;
  logic [N_CFG-1:0]   cfg_in, trig_hw, rise_en, fall_en, pend, evt_cfg;
  logic [N_LINES-1:0] imask, emask;
  logic [31:0]        psel_lo, psel_hi;

  extint_port_mux #(.N_PORTS(N_PORTS), .N_MUX(PIN_W)) u_mux (
    .gpio_in(gpio_in), .psel_lo(psel_lo), .psel_hi(psel_hi), .mux_out(mux_out)
  );

  assign cfg_in = {hi_src, mux_out};

  extint_edge_detect #(.N(N_CFG)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(cfg_in),
    .rise_en(rise_en), .fall_en(fall_en), .trig_hw(trig_hw)
  );

  extint_regs #(.N_CFG(N_CFG), .N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_hw(trig_hw), .imask(imask), .emask(emask),
    .rise_en(rise_en), .fall_en(fall_en), .psel_lo(psel_lo), .psel_hi(psel_hi),
    .pend(pend), .evt_cfg(evt_cfg)
  );

  assign irq_line  = {dir_src & imask[N_LINES-1:N_CFG], pend & imask[N_CFG-1:0]};
  assign evt_pulse = {dir_src & emask[N_LINES-1:N_CFG], evt_cfg};
  assign irq_grp_lo = |irq_line[GLO_H:GLO_L];
  assign irq_grp_hi = |irq_line[GHI_H:GHI_L];

  AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_line[N_CFG-1:0] & ~pend) == '0)); // R4
endmodule

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
  localparam int NP = 4, NC = 26, NL = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP*16-1:0]  gpio_in = '0;
  logic [NC-17:0]    hi_src = '0;
  logic [NL-NC-1:0]  dir_src = '0;
  logic              bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic [NL-1:0]     irq_line, evt_pulse;
  logic              irq_grp_lo, irq_grp_hi;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  extint_ctrl #(.N_PORTS(NP), .N_CFG(NC), .N_LINES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .hi_src(hi_src), .dir_src(dir_src),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_line(irq_line), .evt_pulse(evt_pulse),
    .irq_grp_lo(irq_grp_lo), .irq_grp_hi(irq_grp_hi)
  );

  // {line[4:0], rise, fall, up, imask, emask, exp_pend, exp_irq, exp_evt}
  localparam logic [12:0] VEC [9] = '{
    {5'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {5'd3,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd4,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd7,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd9,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd12, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {5'd15, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd20, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {5'd25, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic set_src(input int line, input logic v);
    if (line < 16) gpio_in[line] = v;
    else hi_src[line-16] = v;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    cycles(2);
    rst_n = 1'b1;
    cycles(1);
    // R1: reset state
    check("R1 irq", irq_line, '0);
    check("R1 evt", evt_pulse, '0);
    check("R1 grp", {30'd0, irq_grp_hi, irq_grp_lo}, '0);
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d);
      check("R1 R12 reg reset", d, '0);
    end

    // Table walk: R2 R3 R4 R5
    for (int v = 0; v < 9; v++) begin
      int ln;
      logic ri, fa, up, im, em, ep, ei, ee;
      {ri, fa, up, im, em, ep, ei, ee} = VEC[v][7:0];
      ln = int'(VEC[v][12:8]);
      wr(extint_pkg::A_PEND, '1);
      wr(extint_pkg::A_RISE,  32'(ri) << ln);
      wr(extint_pkg::A_FALL,  32'(fa) << ln);
      wr(extint_pkg::A_IMASK, 32'(im) << ln);
      wr(extint_pkg::A_EMASK, 32'(em) << ln);
      set_src(ln, ~up);
      cycles(4);
      wr(extint_pkg::A_PEND, '1);
      set_src(ln, up);
      cycles(2);
      check("R2 R3 early", {31'd0, irq_line[ln]}, 32'd0);
      cycles(1);
      rd(extint_pkg::A_PEND, d);
      check("R2 R3 pending", {31'd0, d[ln]}, 32'(ep));
      check("R4 irq", {31'd0, irq_line[ln]}, 32'(ei));
      check("R5 evt", {31'd0, evt_pulse[ln]}, 32'(ee));
      cycles(1);
      check("R5 evt one cycle", {31'd0, evt_pulse[ln]}, 32'd0);
      set_src(ln, 1'b0);
    end
    wr(extint_pkg::A_RISE, '0);
    wr(extint_pkg::A_FALL, '0);
    cycles(4);

    // R6 software trigger
    wr(extint_pkg::A_PEND, '1);
    wr(extint_pkg::A_IMASK, 32'h4);
    wr(extint_pkg::A_EMASK, 32'h4);
    wr(extint_pkg::A_SWT, 32'h4);
    check("R6 irq", irq_line, 32'h4);
    check("R6 evt", evt_pulse, 32'h4);
    rd(extint_pkg::A_SWT, d);
    check("R6 swt readback", d, 32'h4);
    cycles(1);
    check("R6 evt one cycle", evt_pulse, 32'h0);
    wr(extint_pkg::A_SWT, 32'h0);
    rd(extint_pkg::A_PEND, d);
    check("R6 write 0 no effect", d, 32'h4);

    // R7 write-1-to-clear
    wr(extint_pkg::A_PEND, 32'h0);
    rd(extint_pkg::A_PEND, d);
    check("R7 write 0 keeps", d, 32'h4);
    wr(extint_pkg::A_PEND, 32'h4);
    rd(extint_pkg::A_PEND, d);
    check("R7 cleared", d, 32'h0);
    rd(extint_pkg::A_SWT, d);
    check("R7 swt cleared", d, 32'h0);
    check("R7 irq low", irq_line, 32'h0);

    // R8 trigger wins over clear in the same cycle
    wr(extint_pkg::A_RISE, 32'h2);
    wr(extint_pkg::A_SWT, 32'h2);
    set_src(1, 1'b1);
    cycles(2);
    wr(extint_pkg::A_PEND, 32'h2);
    rd(extint_pkg::A_PEND, d);
    check("R8 set wins", d, 32'h2);
    wr(extint_pkg::A_PEND, '1);
    set_src(1, 1'b0);
    wr(extint_pkg::A_RISE, '0);

    // R9 direct lines
    wr(extint_pkg::A_IMASK, 32'h1 << NC);
    wr(extint_pkg::A_EMASK, 32'h0);
    dir_src[0] = 1'b1;
    #1;
    check("R9 direct irq", irq_line, 32'h1 << NC);
    check("R9 direct evt masked", evt_pulse, 32'h0);
    cycles(1);
    wr(extint_pkg::A_EMASK, 32'h1 << NC);
    check("R9 direct evt", evt_pulse, 32'h1 << NC);
    wr(extint_pkg::A_RISE, '1);
    rd(extint_pkg::A_RISE, d);
    check("R9 R12 rise width", d, 32'h03FF_FFFF);
    rd(extint_pkg::A_PEND, d);
    check("R9 no pending", d, 32'h0);
    dir_src[0] = 1'b0;
    #1;
    check("R9 direct follows", irq_line, 32'h0);
    cycles(1);
    wr(extint_pkg::A_RISE, '0);
    wr(extint_pkg::A_PEND, '1);

    // R10 port select
    wr(extint_pkg::A_PSEL0, 32'h0200_0000);
    wr(extint_pkg::A_PSEL1, 32'h0000_3000);
    rd(extint_pkg::A_PSEL0, d);
    check("R10 R12 psel readback", d, 32'h0200_0000);
    wr(extint_pkg::A_RISE, 32'h0000_0840);
    wr(extint_pkg::A_IMASK, 32'h0000_0840);
    gpio_in[6] = 1'b1;
    gpio_in[11] = 1'b1;
    cycles(4);
    check("R10 unselected ignored", irq_line, 32'h0);
    gpio_in[2*16+6] = 1'b1;
    gpio_in[3*16+11] = 1'b1;
    cycles(3);
    check("R10 selected port", irq_line, 32'h0000_0840);
    check("R11 grp lo", {31'd0, irq_grp_lo}, 32'd1);
    check("R11 grp hi", {31'd0, irq_grp_hi}, 32'd1);

    // R11 grouping and masking
    wr(extint_pkg::A_IMASK, 32'h0000_0800);
    check("R11 grp lo masked", {31'd0, irq_grp_lo}, 32'd0);
    check("R11 grp hi kept", {31'd0, irq_grp_hi}, 32'd1);
    wr(extint_pkg::A_PEND, '1);
    check("R11 grp hi cleared", {31'd0, irq_grp_hi}, 32'd0);

    finish_run();
  end
endmodule